// File: doc/BRIEF.md
# Audio Baud-Rate Clock Generator

This block produces two audio bit-rate clocks: one meant for the 44.1 kHz sample-rate family and one for the 48 kHz family. Each generator picks one of four reference clocks. It then divides that reference in two stages: a prescaler whose ratio is a power of two taken in steps of four, followed by an 8-bit counter. The reference clocks are modelled as per-source enable strobes in the single system clock domain. Every divided output is a one-cycle enable pulse.

A narrow write port holds three registers. Two of them are 10-bit rate words. The third is a control word with the two source-select fields and an output-routing mode bit. Each write carries a bit mask, so any field can be changed on its own. A shared clock-out pulse follows generator A, or generator B when the mode bit is set. A write that changes a generator's rate or source restarts that generator from zero. This keeps the first output period after a change full length.

Top module: `audio_brg_top`

## Requirements
- R1: After reset both rate words hold 2, so each generator divides by 6. Both select fields hold 0, which picks reference A. The mode bit is 0. All three outputs are low.
- R2: A rate word holds a prescaler code p in bits 9:8 and a count n in bits 7:0. Once restarted, its generator emits one pulse per (2 << 2p)·(n+1) strobes of its selected reference, giving a prescaler ratio of 2, 8, 32 or 128.
- R3: Each output pulse lasts exactly one cycle. It is high in the cycle after the clock edge that samples the reference strobe completing the period.
- R4: Select codes map to references as follows: 0 picks ref_tick[0] (reference A), 1 picks ref_tick[1] (reference B), 2 picks ref_tick[3] (internal reference), and 4 picks ref_tick[2] (reference C). Codes 3, 5, 6 and 7 pick nothing, and the generator stays low.
- R5: In the control word, generator A's select field is bits 22:20 and generator B's select field is bits 18:16. wr_sel 0 addresses the control word, 1 addresses rate A and 2 addresses rate B.
- R6: Control bit 31 is the routing mode. When it is 1, clkout_tick follows tick_48k. When it is 0, clkout_tick follows tick_44k. The new routing applies from the cycle after the write.
- R7: A write changes only the register bits whose wr_mask bit is 1. A write with wr_mask bit 31 alone changes the mode and leaves both generators' phase untouched.
- R8: A generator restarts its prescaler and counter from zero on a rate write with any of mask bits 9:0 set. It also restarts on a control write with any mask bit of its own select field set. A strobe arriving in the same cycle as the restart is discarded, and the other generator is unaffected.
- R9: While the selected reference gives no strobes, the generator's output stays low.
- R10: A write with wr_sel 3 changes no register and restarts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 4 | Reference strobes: [0] ref A, [1] ref B, [2] ref C, [3] internal |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 rate A, 2 rate B, 3 unused |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| tick_44k | output | 1 | Generator A pulse |
| tick_48k | output | 1 | Generator B pulse |
| clkout_tick | output | 1 | Shared clock-out pulse routed by the mode bit |

## Verification
The assertions check, on every cycle, that no output stays high for two cycles in a row. They also check that a pulse only follows a strobe of the selected reference that was not hit by a restart, that a restart or an unmapped select code keeps the next output low, and that a rate word does not move unless it is written with a nonzero mask. The exact division ratio for each prescaler code and count, the mapping of each select code, the routing of the clock-out pulse, the masked-write isolation and the restart phase can only be shown by the bench's scenarios. The bench compares each output cycle against a strobe-counting model.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int DATA_W    = 32;
  localparam int PCODE_W   = 2;
  localparam int CNT_W     = 8;
  localparam int RATE_W    = PCODE_W + CNT_W;
  localparam int SEL_W     = 3;
  localparam int N_GEN     = 2;
  localparam int N_REF     = 4;
  localparam int MODE_BIT  = 31;
  localparam int SEL_A_LSB = 20;
  localparam int SEL_B_LSB = 16;
  localparam logic [RATE_W-1:0] RATE_RST = RATE_W'(2);

  typedef enum logic [SEL_W-1:0] {
    SRC_REF_A = 3'd0,
    SRC_REF_B = 3'd1,
    SRC_INT   = 3'd2,
    SRC_REF_C = 3'd4
  } src_code_e;

  typedef enum logic [1:0] {
    WSEL_CTRL   = 2'd0,
    WSEL_RATE_A = 2'd1,
    WSEL_RATE_B = 2'd2,
    WSEL_NONE   = 2'd3
  } wsel_e;

  function automatic int sel_lsb(input int g);
    return (g == 0) ? SEL_A_LSB : SEL_B_LSB;
  endfunction
endpackage

// File: rtl/brg_regs.sv
module brg_regs
  import brg_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [DATA_W-1:0]              wr_mask,
  output logic [N_GEN-1:0][RATE_W-1:0]   rate,
  output logic [N_GEN-1:0][SEL_W-1:0]    sel,
  output logic                           mode_q,
  output logic [N_GEN-1:0]               restart
);
  logic [N_GEN-1:0][RATE_W-1:0] rate_d;
  logic [N_GEN-1:0][SEL_W-1:0]  sel_d;
  logic                         mode_d;
  logic                         ctrl_wr;

  assign ctrl_wr = wr_en && (wr_sel == WSEL_CTRL);

  always_comb begin
    mode_d = mode_q;
    if (ctrl_wr && wr_mask[MODE_BIT]) mode_d = wr_data[MODE_BIT];
  end

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    localparam int LSB = sel_lsb(g);
    localparam logic [1:0] RSEL = (g == 0) ? WSEL_RATE_A : WSEL_RATE_B;
    logic               rate_wr;
    logic [SEL_W-1:0]   smask;
    logic [RATE_W-1:0]  rmask;

    assign rate_wr = wr_en && (wr_sel == RSEL);
    assign smask   = wr_mask[LSB +: SEL_W];
    assign rmask   = wr_mask[RATE_W-1:0];

    always_comb begin
      rate_d[g] = rate[g];
      sel_d[g]  = sel[g];
      if (rate_wr)
        rate_d[g] = (rate[g] & ~rmask) | (wr_data[RATE_W-1:0] & rmask);
      if (ctrl_wr)
        sel_d[g] = (sel[g] & ~smask) | (wr_data[LSB +: SEL_W] & smask);
    end

    assign restart[g] = (rate_wr && (|rmask)) || (ctrl_wr && (|smask));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rate[g] <= RATE_RST;
        sel[g]  <= SRC_REF_A;
      end else begin
        rate[g] <= rate_d[g];
        sel[g]  <= sel_d[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/brg_src_mux.sv
module brg_src_mux
  import brg_pkg::*;
(
  input  logic [N_REF-1:0] ref_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             src_tick
);
  always_comb begin
    unique case (sel)
      SRC_REF_A: src_tick = ref_tick[0];
      SRC_REF_B: src_tick = ref_tick[1];
      SRC_REF_C: src_tick = ref_tick[2];
      SRC_INT:   src_tick = ref_tick[3];
      default:   src_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/brg_divider.sv
module brg_divider
  import brg_pkg::*;
#(
  parameter int P_W = PCODE_W,
  parameter int C_W = CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           src_tick,
  input  logic [P_W+C_W-1:0] rate,
  output logic           pulse_q
);
  localparam int PRE_W = 2 * ((1 << P_W) - 1) + 1;

  logic [PRE_W-1:0] pre_q, pre_d, pre_last;
  logic [C_W-1:0]   cnt_q, cnt_d, cnt_last;
  logic [P_W:0]     shamt;
  logic             pulse_d;

  assign shamt    = (P_W+1)'(PRE_W - 1) - {rate[P_W+C_W-1:C_W], 1'b0};
  assign pre_last = {PRE_W{1'b1}} >> shamt;
  assign cnt_last = rate[C_W-1:0];

  always_comb begin
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (restart) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (src_tick) begin
      if (pre_q == pre_last) begin
        pre_d = '0;
        if (cnt_q == cnt_last) begin
          cnt_d   = '0;
          pulse_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end
endmodule

// File: rtl/audio_brg_top.sv
module audio_brg_top
  import brg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REF-1:0]  ref_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  output logic              tick_44k,
  output logic              tick_48k,
  output logic              clkout_tick
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [N_GEN-1:0][RATE_W-1:0] rate_w;
  logic [N_GEN-1:0][SEL_W-1:0]  sel_w;
  logic [N_GEN-1:0]             restart_w;
  logic [N_GEN-1:0]             src_w;
  logic [N_GEN-1:0]             pulse_w;
  logic                         mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  brg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .rate    (rate_w),
    .sel     (sel_w),
    .mode_q  (mode_w),
    .restart (restart_w)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_chan
    brg_src_mux u_mux (
      .ref_tick (ref_tick),
      .sel      (sel_w[g]),
      .src_tick (src_w[g])
    );
    brg_divider u_div (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .restart  (restart_w[g]),
      .src_tick (src_w[g]),
      .rate     (rate_w[g]),
      .pulse_q  (pulse_w[g])
    );
  end

  assign tick_44k    = pulse_w[0];
  assign tick_48k    = pulse_w[1];
  assign clkout_tick = mode_w ? pulse_w[1] : pulse_w[0];
endmodule

// File: rtl/brg_checker.sv
module brg_checker
  import brg_pkg::*;
(
  input logic                         clk,
  input logic                         rst_int_n,
  input logic                         wr_en,
  input logic [1:0]                   wr_sel,
  input logic [DATA_W-1:0]            wr_mask,
  input logic [N_GEN-1:0][RATE_W-1:0] rate_w,
  input logic [N_GEN-1:0][SEL_W-1:0]  sel_w,
  input logic [N_GEN-1:0]             restart_w,
  input logic [N_GEN-1:0]             src_w,
  input logic                         tick_44k,
  input logic                         tick_48k
);
  // R3: a pulse lasts one cycle (smallest division is 2)
  p_one_cycle_a_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    tick_44k |=> !tick_44k);
  p_one_cycle_b_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    tick_48k |=> !tick_48k);

  // R9: a pulse needs a strobe of the selected source that was not discarded
  p_needs_src_a_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    tick_44k |-> ($past(src_w[0]) && !$past(restart_w[0])));
  p_needs_src_b_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    tick_48k |-> ($past(src_w[1]) && !$past(restart_w[1])));

  // R8: a restart keeps the next output low
  p_restart_quiet_a_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart_w[0] |=> !tick_44k);
  p_restart_quiet_b_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart_w[1] |=> !tick_48k);

  // R4: an unmapped select code never yields a pulse
  p_bad_code_a_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_w[0] inside {3'd3, 3'd5, 3'd6, 3'd7}) |=> !tick_44k);
  p_bad_code_b_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_w[1] inside {3'd3, 3'd5, 3'd6, 3'd7}) |=> !tick_48k);

  // R7: a rate word only moves on a write to it with a nonzero mask
  p_rate_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_en && wr_sel == 2'd1 && (|wr_mask[RATE_W-1:0])) |=> $stable(rate_w[0]));
  p_rate_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_en && wr_sel == 2'd2 && (|wr_mask[RATE_W-1:0])) |=> $stable(rate_w[1]));
endmodule

bind audio_brg_top brg_checker u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_mask   (wr_mask),
  .rate_w    (rate_w),
  .sel_w     (sel_w),
  .restart_w (restart_w),
  .src_w     (src_w),
  .tick_44k  (tick_44k),
  .tick_48k  (tick_48k)
);

// File: tb/audio_brg_top_tb.sv
module audio_brg_top_tb;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [3:0]  ref_tick;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] wr_mask;
  logic        tick_44k, tick_48k, clkout_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] q_val[$];
  string      q_tag[$];

  int         k_m[2];
  logic [9:0] rate_m[2];
  logic [2:0] sel_m[2];
  logic       mode_m;

  audio_brg_top u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_mask(wr_mask),
    .tick_44k(tick_44k), .tick_48k(tick_48k), .clkout_tick(clkout_tick)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // R4 mapping of select codes to strobe index
  function automatic int src_idx(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 3;
      3'd4: return 2;
      default: return -1;
    endcase
  endfunction

  // R2 division
  function automatic int div_of(input logic [9:0] r);
    return (2 << (2 * int'(r[9:8]))) * (int'(r[7:0]) + 1);
  endfunction

  task automatic cyc(input logic [3:0] t, input logic w, input logic [1:0] s,
                     input logic [31:0] d, input logic [31:0] m, input string tag);
    logic [1:0] rs;
    logic [1:0] pl;
    @(negedge clk);
    ref_tick = t; wr_en = w; wr_sel = s; wr_data = d; wr_mask = m;
    rs[0] = w && ((s == 2'd1 && |m[9:0]) || (s == 2'd0 && |m[22:20]));
    rs[1] = w && ((s == 2'd2 && |m[9:0]) || (s == 2'd0 && |m[18:16]));
    for (int g = 0; g < 2; g++) begin
      pl[g] = 1'b0;
      if (rs[g]) begin
        k_m[g] = 0;
      end else if (src_idx(sel_m[g]) >= 0 && t[src_idx(sel_m[g])]) begin
        k_m[g]++;
        if (k_m[g] >= div_of(rate_m[g])) begin
          pl[g] = 1'b1;
          k_m[g] = 0;
        end
      end
    end
    if (w) begin
      if (s == 2'd1) rate_m[0] = (rate_m[0] & ~m[9:0]) | (d[9:0] & m[9:0]);
      if (s == 2'd2) rate_m[1] = (rate_m[1] & ~m[9:0]) | (d[9:0] & m[9:0]);
      if (s == 2'd0) begin
        sel_m[0] = (sel_m[0] & ~m[22:20]) | (d[22:20] & m[22:20]);
        sel_m[1] = (sel_m[1] & ~m[18:16]) | (d[18:16] & m[18:16]);
        if (m[31]) mode_m = d[31];
      end
    end
    q_val.push_back({pl[0], pl[1], mode_m ? pl[1] : pl[0]});
    q_tag.push_back(tag);
  endtask

  task automatic run(input int n, input logic [3:0] t, input string tag);
    for (int i = 0; i < n; i++) cyc(t, 1'b0, 2'd0, 32'd0, 32'd0, tag);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d, input logic [31:0] m,
                    input logic [3:0] t, input string tag);
    cyc(t, 1'b1, s, d, m, tag);
  endtask

  // monitor: compares each cycle's outputs against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q_val.size() > 0) begin
        logic [2:0] v;
        string tg;
        v  = q_val.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if ({tick_44k, tick_48k, clkout_tick} !== v) begin
          errors++;
          $display("FAIL %s at %0t: a/b/out actual %b%b%b expected %b",
                   tg, $time, tick_44k, tick_48k, clkout_tick, v);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_tick = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; wr_mask = '0;
    for (int g = 0; g < 2; g++) begin
      k_m[g] = 0; rate_m[g] = 10'd2; sel_m[g] = 3'd0;
    end
    mode_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if ({tick_44k, tick_48k, clkout_tick} !== 3'b000) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b%b%b expected 000", tick_44k, tick_48k, clkout_tick);
    end

    run(20, 4'b0001, "R1 default divide-by-6 from ref A");
    run(10, 4'b1110, "R9 no strobes on selected ref");

    wr(2'd1, 32'h000, 32'h3FF, 4'b0000, "R2 rate A p0 n0");
    run(12, 4'b1111, "R2 divide-by-2");
    wr(2'd1, 32'h103, 32'h3FF, 4'b1111, "R8 restart discards strobe");
    run(70, 4'b1111, "R2 p1 n3 divide-by-32");
    wr(2'd2, 32'h300, 32'h3FF, 4'b0000, "R2 rate B p3 n0");
    run(270, 4'b1111, "R2 divide-by-128");
    wr(2'd2, 32'h201, 32'h3FF, 4'b0000, "R2 rate B p2 n1");
    run(140, 4'b0001, "R2 divide-by-64");

    // R5 select fields: A <- code 4 (ref C), B <- code 2 (internal)
    wr(2'd0, 32'h0042_0000, 32'h0077_0000, 4'b0000, "R5 select write");
    run(70, 4'b0100, "R4 code 4 uses ref_tick[2]");
    run(140, 4'b1000, "R4 code 2 uses ref_tick[3]");
    wr(2'd0, 32'h0011_0000, 32'h0077_0000, 4'b0000, "R5 select A=1 B=1");
    run(140, 4'b0010, "R4 code 1 uses ref_tick[1]");

    // R6/R7 mode-only write leaves generator phase intact
    run(13, 4'b0010, "R7 partial period");
    wr(2'd0, 32'hFFFF_FFFF, 32'h8000_0000, 4'b0010, "R7 mode-only masked write");
    run(140, 4'b0010, "R6 clkout follows B");

    // R4 unmapped code on A
    wr(2'd0, 32'h0050_0000, 32'h0070_0000, 4'b1111, "R4 code 5 select");
    run(40, 4'b1111, "R4 unmapped code stays low");
    wr(2'd0, 32'h0000_0000, 32'h8070_0000, 4'b0000, "R6 mode back to A");

    // R8 mid-count restart of A only
    wr(2'd1, 32'h100, 32'h3FF, 4'b0000, "R8 rate A divide-by-8");
    run(5, 4'b0011, "R8 partial count");
    wr(2'd1, 32'h100, 32'h3FF, 4'b0011, "R8 restart mid-count");
    run(20, 4'b0011, "R8 full period after restart");

    // R10 write to unused slot
    run(3, 4'b0001, "R10 partial");
    wr(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0001, "R10 unused slot write");
    run(20, 4'b0011, "R10 no effect");

    // R7 zero-mask rate write is not a restart
    wr(2'd1, 32'h3FF, 32'h000, 4'b0001, "R7 zero-mask write");
    run(20, 4'b0011, "R7 zero mask no change");

    run(30, 4'b0000, "R9 idle references");
    for (int i = 0; i < 400; i++)
      cyc(4'($urandom_range(0, 15)), 1'b0, 2'd0, 32'd0, 32'd0, "R3 sparse strobes");

    @(negedge clk);
    while (q_val.size() > 0) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule